// File: doc/BRIEF.md
# Static-Schedule All-to-All Exchanger

This block redistributes a volume that is split across several pipeline endpoints, so that every endpoint ends up holding the part of every other endpoint's data that belongs to it. Each endpoint has one 256-bit input stream and one 256-bit output stream, and both use valid/ready handshakes. A single start pulse begins an exchange. No word carries a header. The destination of every word follows from its position in the input stream under a fixed rotation schedule.

The exchange runs in as many rounds as there are endpoints. In round r, endpoint n streams a fixed number of words for endpoint (n+r) mod N. Round 0 is therefore the local loopback, and all later rounds cross to other endpoints. Every source and destination pair has a small FIFO at its crosspoint. When a FIFO is full, it holds back only the source that is writing into it. The input round moves on once every source has delivered its quota for that round. Each output drains its column of crosspoints in round order. The block reports completion once every output has delivered the full exchange.

Top module: `a2a_exchanger`

## Requirements
- R1: After reset, in_ready and out_valid are all low, and busy and done are low.
- R2: While no exchange is running, in_ready stays low and out_valid stays low for every endpoint, whatever is applied to in_valid.
- R3: In input round r (r = 0 .. N_EP-1), a word accepted from source n is delivered, with all 256 bits unchanged, on output (n+r) mod N_EP. Round 0 is the loopback to the same endpoint.
- R4: Each source accepts exactly WORDS_PER_ROUND words per round. A source that has finished its quota keeps in_ready low until every source has finished the same round.
- R5: Output d delivers N_EP×WORDS_PER_ROUND words in total. For output round r it delivers WORDS_PER_ROUND words from source (d−r) mod N_EP in their arrival order, and the rounds come out in ascending order.
- R6: While out_ready of an output is low, its out_valid and out_data hold. A full crosspoint FIFO (XP_DEPTH words) stalls only the source that writes into it, and the other sources keep transferring.
- R7: Two cycles after the last output word is transferred, done is high and busy is low. In the cycle between, done is still low. Done then stays high until the next accepted start.
- R8: A start pulse while busy is high is ignored. The running exchange goes on with no extra or repeated words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle pulse that begins an exchange when the block is idle |
| in_valid | input | N_EP | Per-source input word valid |
| in_data | input | N_EP×W | Per-source input words, source n at bits [n×W +: W] |
| in_ready | output | N_EP | Per-source input ready |
| out_valid | output | N_EP | Per-destination output word valid |
| out_data | output | N_EP×W | Per-destination output words, destination d at bits [d×W +: W] |
| out_ready | input | N_EP | Per-destination output ready |
| busy | output | 1 | High while an exchange is in progress |
| done | output | 1 | High once the last exchange has fully drained |

## Verification
The bench builds the block with four endpoints, 256-bit words, four words per round and a crosspoint depth of two. The quota is then twice the FIFO depth, so a stalled output fills its crosspoint partway through a round, and the bench can observe a source blocked after exactly two words while a neighbour completes its four. Four endpoints give three crossing rounds plus the loopback. Every rotation offset, including the wrap-around of (d−r) mod N, therefore appears within one short exchange.

// File: rtl/a2a_pkg.sv
`timescale 1ns/1ps
package a2a_pkg;
  // Destination of a source in a round: (base + off) mod n
  function automatic int unsigned rot_add(input int unsigned base,
                                          input int unsigned off,
                                          input int unsigned n);
    return (base + off) % n;
  endfunction

  // Source feeding a destination in a round: (base - off) mod n
  function automatic int unsigned rot_sub(input int unsigned base,
                                          input int unsigned off,
                                          input int unsigned n);
    return (base + n - (off % n)) % n;
  endfunction
endpackage

// File: rtl/a2a_xp_fifo.sv
`timescale 1ns/1ps
module a2a_xp_fifo #(
  parameter int W     = 256,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] din,
  input  logic         rd,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_wr, do_rd, en;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign en    = do_wr || do_rd;
  assign dout  = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_wr) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_rd) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_wr && !do_rd)      cnt_d = cnt_q + 1'b1;
    else if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= din;
  end
endmodule

// File: rtl/a2a_src_seq.sv
`timescale 1ns/1ps
module a2a_src_seq
  import a2a_pkg::*;
#(
  parameter int N_EP = 4,
  parameter int WPR  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [N_EP-1:0]      in_valid,
  input  logic [N_EP*N_EP-1:0] xp_full,
  output logic [N_EP-1:0]      in_ready,
  output logic [N_EP*N_EP-1:0] xp_wr,
  output logic                 active
);
  localparam int CW = $clog2(WPR + 1);
  localparam int RW = (N_EP > 1) ? $clog2(N_EP) : 1;

  logic          act_q, act_d;
  logic [RW-1:0] rnd_q, rnd_d;
  logic [CW-1:0] cnt_q [N_EP];
  logic [CW-1:0] cnt_d [N_EP];
  logic          all_fin, en;

  assign active = act_q;
  assign en     = go || act_q;

  // Steer each source to its crosspoint for the current round
  always_comb begin
    xp_wr   = '0;
    in_ready = '0;
    all_fin = 1'b1;
    for (int s = 0; s < N_EP; s++) begin
      int unsigned tgt;
      tgt = rot_add(s, int'(rnd_q), N_EP);
      in_ready[s] = act_q && (cnt_q[s] != CW'(WPR)) && !xp_full[s*N_EP + tgt];
      xp_wr[s*N_EP + tgt] = in_ready[s] && in_valid[s];
      if (cnt_q[s] != CW'(WPR)) all_fin = 1'b0;
    end
  end

  always_comb begin
    act_d = act_q;
    rnd_d = rnd_q;
    for (int s = 0; s < N_EP; s++) cnt_d[s] = cnt_q[s];
    if (go) begin
      act_d = 1'b1;
      rnd_d = '0;
      for (int s = 0; s < N_EP; s++) cnt_d[s] = '0;
    end else if (act_q) begin
      if (all_fin) begin
        for (int s = 0; s < N_EP; s++) cnt_d[s] = '0;
        if (rnd_q == RW'(N_EP - 1)) act_d = 1'b0;
        else                        rnd_d = rnd_q + 1'b1;
      end else begin
        for (int s = 0; s < N_EP; s++)
          if (in_ready[s] && in_valid[s]) cnt_d[s] = cnt_q[s] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rnd_q <= '0;
      for (int s = 0; s < N_EP; s++) cnt_q[s] <= '0;
    end else if (en) begin
      act_q <= act_d;
      rnd_q <= rnd_d;
      for (int s = 0; s < N_EP; s++) cnt_q[s] <= cnt_d[s];
    end
  end
endmodule

// File: rtl/a2a_sink_seq.sv
`timescale 1ns/1ps
module a2a_sink_seq
  import a2a_pkg::*;
#(
  parameter int N_EP  = 4,
  parameter int WPR   = 4,
  parameter int W     = 256,
  parameter int D_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [N_EP-1:0]   col_empty,
  input  logic [N_EP*W-1:0] col_data,
  input  logic              out_ready,
  output logic [N_EP-1:0]   col_pop,
  output logic              out_valid,
  output logic [W-1:0]      out_data,
  output logic              active
);
  localparam int OCW = (WPR > 1) ? $clog2(WPR) : 1;
  localparam int RW  = (N_EP > 1) ? $clog2(N_EP) : 1;

  logic           act_q, act_d;
  logic [RW-1:0]  rnd_q, rnd_d;
  logic [OCW-1:0] cnt_q, cnt_d;
  logic           fire, en;
  int unsigned    sel;

  assign active = act_q;
  assign en     = go || fire;

  // Column source for this output's current round
  always_comb begin
    sel       = rot_sub(D_IDX, int'(rnd_q), N_EP);
    out_valid = act_q && !col_empty[sel];
    out_data  = col_data[sel*W +: W];
    fire      = out_valid && out_ready;
    col_pop   = '0;
    col_pop[sel] = fire;
  end

  always_comb begin
    act_d = act_q;
    rnd_d = rnd_q;
    cnt_d = cnt_q;
    if (go) begin
      act_d = 1'b1;
      rnd_d = '0;
      cnt_d = '0;
    end else if (fire) begin
      if (cnt_q == OCW'(WPR - 1)) begin
        cnt_d = '0;
        if (rnd_q == RW'(N_EP - 1)) act_d = 1'b0;
        else                        rnd_d = rnd_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rnd_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      act_q <= act_d;
      rnd_q <= rnd_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/a2a_exchanger.sv
`timescale 1ns/1ps
module a2a_exchanger #(
  parameter int N_EP            = 4,
  parameter int W               = 256,
  parameter int WORDS_PER_ROUND = 4,
  parameter int XP_DEPTH        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N_EP-1:0]   in_valid,
  input  logic [N_EP*W-1:0] in_data,
  output logic [N_EP-1:0]   in_ready,
  output logic [N_EP-1:0]   out_valid,
  output logic [N_EP*W-1:0] out_data,
  input  logic [N_EP-1:0]   out_ready,
  output logic              busy,
  output logic              done
);
  localparam int NXP = N_EP * N_EP;

  logic [NXP-1:0]    xp_wr, xp_rd, xp_full, xp_empty;
  logic [W-1:0]      xp_dout [NXP];
  logic [N_EP-1:0]   col_empty [N_EP];
  logic [N_EP*W-1:0] col_data  [N_EP];
  logic [N_EP-1:0]   col_pop   [N_EP];
  logic [N_EP-1:0]   sink_act;
  logic              src_act, go, finish;
  logic              run_q, run_d, done_q, done_d, en;

  assign go     = start && !run_q;
  assign finish = run_q && !src_act && !(|sink_act);
  assign en     = go || finish;
  assign busy   = run_q;
  assign done   = done_q;

  a2a_src_seq #(.N_EP(N_EP), .WPR(WORDS_PER_ROUND)) u_src (
    .clk(clk), .rst_n(rst_n), .go(go), .in_valid(in_valid),
    .xp_full(xp_full), .in_ready(in_ready), .xp_wr(xp_wr), .active(src_act)
  );

  for (genvar s = 0; s < N_EP; s++) begin : g_row
    for (genvar d = 0; d < N_EP; d++) begin : g_col
      a2a_xp_fifo #(.W(W), .DEPTH(XP_DEPTH)) u_xp (
        .clk(clk), .rst_n(rst_n),
        .wr(xp_wr[s*N_EP+d]), .din(in_data[s*W +: W]),
        .rd(xp_rd[s*N_EP+d]), .dout(xp_dout[s*N_EP+d]),
        .full(xp_full[s*N_EP+d]), .empty(xp_empty[s*N_EP+d])
      );
      assign col_empty[d][s]         = xp_empty[s*N_EP+d];
      assign col_data[d][s*W +: W]   = xp_dout[s*N_EP+d];
      assign xp_rd[s*N_EP+d]         = col_pop[d][s];
    end
  end

  for (genvar d = 0; d < N_EP; d++) begin : g_sink
    a2a_sink_seq #(.N_EP(N_EP), .WPR(WORDS_PER_ROUND), .W(W), .D_IDX(d)) u_sink (
      .clk(clk), .rst_n(rst_n), .go(go),
      .col_empty(col_empty[d]), .col_data(col_data[d]),
      .out_ready(out_ready[d]), .col_pop(col_pop[d]),
      .out_valid(out_valid[d]), .out_data(out_data[d*W +: W]),
      .active(sink_act[d])
    );
  end

  always_comb begin
    run_d  = run_q;
    done_d = done_q;
    if (go) begin
      run_d  = 1'b1;
      done_d = 1'b0;
    end else if (finish) begin
      run_d  = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (en) begin
      run_q  <= run_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/a2a_exchanger_chk.sv
`timescale 1ns/1ps
module a2a_exchanger_chk #(
  parameter int N_EP = 4,
  parameter int W    = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [N_EP-1:0]   in_ready,
  input logic [N_EP-1:0]   out_valid,
  input logic [N_EP*W-1:0] out_data,
  input logic [N_EP-1:0]   out_ready,
  input logic              busy,
  input logic              done
);
  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (in_ready == '0)); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (out_valid == '0)); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R7
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R8

  for (genvar d = 0; d < N_EP; d++) begin : g_hold
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[d] && !out_ready[d]) |=> (out_valid[d] && $stable(out_data[d*W +: W]))); // R6
  end
endmodule

bind a2a_exchanger a2a_exchanger_chk #(.N_EP(N_EP), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
  .busy(busy), .done(done)
);

// File: tb/a2a_exchanger_bench.sv
`timescale 1ns/1ps
module a2a_exchanger_bench;
  localparam int N     = 4;
  localparam int W     = 256;
  localparam int WPR   = 4;
  localparam int DEPTH = 2;
  localparam int TOTAL = N * WPR;

  logic           clk, rst_n, start;
  logic [N-1:0]   in_valid, in_ready, out_valid, out_ready;
  logic [N*W-1:0] in_data, out_data;
  logic           busy, done;

  int checks, failures, cycles;
  int sent [N];
  int recv [N];
  bit finished;

  a2a_exchanger #(.N_EP(N), .W(W), .WORDS_PER_ROUND(WPR), .XP_DEPTH(DEPTH)) u_a2a_exchanger (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mk(input int ex, input int s, input int d, input int idx);
    logic [31:0] lo;
    lo = {8'(ex), 8'(s), 8'(d), 8'(idx)};
    return {(W/32){lo}};
  endfunction

  function automatic bit vgate(input int mode, input int s, input int cyc);
    if (mode == 1) return ((cyc * 7 + s * 3) % 5) != 0;
    if (mode == 3) return (s != 3) || (cyc >= 30);
    return 1'b1;
  endfunction

  function automatic bit rgate(input int mode, input int d, input int cyc);
    if (mode == 1) return ((cyc * 5 + d) % 3) != 0;
    if (mode == 2) return (d != 0) || (cyc >= 40);
    return 1'b1;
  endfunction

  // One full exchange; mode selects the stimulus pattern
  task automatic run_exchange(input int mode, input int ex, input string tag);
    bit [N-1:0] inf, outf;
    bit ended;
    inf = '0; outf = '0; ended = 1'b0;
    for (int i = 0; i < N; i++) begin sent[i] = 0; recv[i] = 0; end
    for (int cyc = 0; cyc < 3000 && !ended; cyc++) begin
      @(negedge clk);
      for (int s = 0; s < N; s++) if (inf[s]) sent[s]++;
      for (int d = 0; d < N; d++) if (outf[d]) recv[d]++;
      if (mode == 2 && cyc == 40) begin
        chk(sent[0] == DEPTH, "R6 blocked source words", sent[0], DEPTH);
        chk(sent[1] == WPR, "R6 other source words", sent[1], WPR);
      end
      if (mode == 3 && cyc == 30) begin
        chk(sent[0] == WPR, "R4 quota before round advance", sent[0], WPR);
        chk(in_ready[0] == 1'b0, "R4 ready low after quota", in_ready[0], 0);
      end
      ended = 1'b1;
      for (int d = 0; d < N; d++) if (recv[d] < TOTAL) ended = 1'b0;
      if (ended) begin
        in_valid = '0; out_ready = '0; start = 1'b0;
      end else begin
        start = (cyc == 0) || (mode == 4 && cyc == 6);
        for (int s = 0; s < N; s++) begin
          in_valid[s] = (sent[s] < TOTAL) && vgate(mode, s, cyc);
          in_data[s*W +: W] = mk(ex, s, (s + sent[s] / WPR) % N, sent[s] % WPR);
        end
        for (int d = 0; d < N; d++) out_ready[d] = rgate(mode, d, cyc);
        #1;
        inf  = in_valid & in_ready;
        outf = out_valid & out_ready;
        for (int d = 0; d < N; d++) begin
          if (outf[d]) begin
            int k;
            logic [W-1:0] exp;
            k = recv[d];
            if (k >= TOTAL) chk(1'b0, {tag, " R5 extra word"}, k, TOTAL - 1);
            else begin
              exp = mk(ex, (d + N - k / WPR) % N, d, k % WPR);
              chk(out_data[d*W +: W] == exp, {tag, " R3 R5 word"},
                  longint'(out_data[d*W +: 32]), longint'(exp[31:0]));
            end
          end
        end
      end
    end
    chk(ended, {tag, " R5 all words delivered"}, ended, 1);
    for (int d = 0; d < N; d++) chk(recv[d] == TOTAL, {tag, " R5 word count"}, recv[d], TOTAL);
    for (int s = 0; s < N; s++) chk(sent[s] == TOTAL, {tag, " R4 source count"}, sent[s], TOTAL);
    chk(done == 1'b0 && busy == 1'b1, {tag, " R7 done one cycle later"}, {done, busy}, 2'b01);
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, {tag, " R7 done raised"}, {done, busy}, 2'b10);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(done == 1'b1, {tag, " R7 done holds"}, done, 1);
      chk(out_valid == '0, {tag, " R8 no extra output"}, out_valid, 0);
    end
  endtask

  task automatic idle_test(input string tag);
    in_valid = '1; out_ready = '1; start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      chk(in_ready == '0, {tag, " R2 in_ready idle"}, in_ready, 0);
      chk(out_valid == '0, {tag, " R2 out_valid idle"}, out_valid, 0);
    end
    in_valid = '0;
  endtask

  task automatic reset_test();
    rst_n = 1'b0; start = 1'b0; in_valid = '0; in_data = '0; out_ready = '0;
    repeat (3) @(negedge clk);
    chk(in_ready == '0 && out_valid == '0, "R1 handshake outputs", {in_ready, out_valid}, 0);
    chk(busy == 1'b0 && done == 1'b0, "R1 status", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 after release", {busy, done}, 0);
  endtask

  initial begin
    checks = 0; failures = 0; cycles = 0; finished = 1'b0;
    reset_test();
    idle_test("pre");
    run_exchange(0, 8'h11, "full_rate");
    idle_test("post");
    run_exchange(1, 8'h22, "gapped");
    run_exchange(2, 8'h33, "stall_out0");
    run_exchange(3, 8'h44, "late_src3");
    run_exchange(4, 8'h55, "restart_busy");
    summary();
  end
endmodule